// File: doc/BRIEF.md
# Sequential Restoring Binary Divider

This block divides one unsigned integer by another using binary long division, producing a single quotient bit per clock. A one-cycle start strobe captures both operands while the unit is idle. Over the following cycles a down-counter names which dividend bit, from the most significant downward, joins the partial remainder. In each of those cycles the partial remainder is shifted left and the divisor is subtracted whenever it fits.

When the last bit has been processed the block raises a one-cycle done flag. Quotient and remainder then stay on the outputs until the next accepted start. A zero divisor needs no special path: it produces an all-ones quotient and returns the dividend as the remainder, after the same number of cycles as any other division.

The operand width is a parameter, with a default of 32. The counter width is derived from it.

Top module: `restoring_divider`

## Requirements
- R1: While reset is held low and on the first cycle after it, done is 0 and quotient and remainder are all zeros.
- R2: A start seen while no division is running captures both operands and clears quotient and remainder on that same clock edge.
- R3: A start that arrives while a division is running is ignored: neither the operands it carries nor its timing alter the result or the latency of the running division.
- R4: Done is high for exactly one cycle, on the WIDTH-th rising edge after the edge that accepted start.
- R5: For a nonzero divisor, the quotient equals floor(dividend / divisor) and the remainder equals dividend mod divisor (e.g. 45 / 3 gives 15 remainder 0).
- R6: For a zero divisor, the quotient is all ones and the remainder equals the dividend, with the same latency as in R4.
- R7: After done, quotient and remainder hold their values for as long as start stays low, whatever the operand inputs do.
- R8: Every computing cycle lowers the bit-index counter by one, starting from WIDTH-1, and done never coincides with a computing cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Strobe that begins a division when idle |
| dividend | input | WIDTH | Numerator, captured on an accepted start |
| divisor | input | WIDTH | Denominator, captured on an accepted start |
| done | output | 1 | One-cycle pulse when the result is ready |
| quotient | output | WIDTH | Quotient, held after done |
| remainder | output | WIDTH | Remainder, held after done |

## Verification
The bench builds the block twice. One instance has WIDTH set to 6, which makes an exhaustive sweep of all 4096 dividend and divisor pairs affordable. That sweep covers every zero divisor, every divisor larger than the dividend, and every all-ones operand, and it checks the latency of each run. The second instance keeps the default WIDTH of 32. It runs directed cases (45 / 3, a zero divisor, extreme operands) and a stream of generated operands, so the full-width counter and the most-significant-bit path are exercised as well.

// File: rtl/div_pkg.sv
// Shared types for the restoring divider.
// Assumes: nothing beyond a synthesizable two-state sequencer.
package div_pkg;
    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } div_state_e;
endpackage

// File: rtl/div_seq_ctrl.sv
// Sequencer of the restoring divider: accepts start when idle, then
// counts the bit index down from WIDTH-1 to 0, one step per cycle, and
// pulses done after the final step.
// Assumes: WIDTH >= 2; start is ignored while a run is in progress.
module div_seq_ctrl
    import div_pkg::*;
#(
    parameter  int WIDTH = 32,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             load,
    output logic             step,
    output logic             done,
    output logic [IDX_W-1:0] bit_idx
);
    localparam logic [IDX_W-1:0] TOP_IDX = IDX_W'(WIDTH - 1);

    div_state_e       state_q;
    logic [IDX_W-1:0] cnt_q;

    // Start is taken only while idle; every running cycle is a step.
    assign load    = start && (state_q == ST_IDLE);
    assign step    = (state_q == ST_RUN);
    assign bit_idx = cnt_q;

    // State, down-counter and the done pulse register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cnt_q   <= '0;
            done    <= 1'b0;
        end else begin
            done <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_RUN;
                        cnt_q   <= TOP_IDX;
                    end
                end
                ST_RUN: begin
                    if (cnt_q == '0) begin
                        state_q <= ST_IDLE;
                        done    <= 1'b1;
                    end else begin
                        cnt_q <= cnt_q - 1'b1;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R2: an accepted start opens a run at the top bit index.
    a_r2_accept_top: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (step && bit_idx == TOP_IDX));

    // R8: each non-final step lowers the index by one and keeps running.
    a_r8_count_down: assert property (@(posedge clk) disable iff (!rst_n)
        (step && bit_idx != '0) |=> (step && bit_idx == $past(bit_idx) - 1'b1));

    // R8: done never overlaps a computing cycle.
    a_r8_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !step);

    // R4: done is a single-cycle pulse.
    a_r4_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R4: the final step is followed by done.
    a_r4_done_after_last: assert property (@(posedge clk) disable iff (!rst_n)
        (step && bit_idx == '0) |=> done);
endmodule

// File: rtl/div_step.sv
// One restoring-division step, purely combinational: shift the partial
// remainder left, append the chosen dividend bit, subtract the divisor
// when it fits, and append the fit flag to the quotient.
// Assumes: rem_in < divisor whenever divisor is nonzero, so the result
// fits in WIDTH bits.
module div_step #(
    parameter int WIDTH = 32
) (
    input  logic [WIDTH-1:0] rem_in,
    input  logic             bit_in,
    input  logic [WIDTH-1:0] divisor,
    input  logic [WIDTH-1:0] quo_in,
    output logic [WIDTH-1:0] rem_out,
    output logic [WIDTH-1:0] quo_out
);
    logic [WIDTH:0] shifted;
    logic [WIDTH:0] dvs_ext;
    logic           fits;

    // Compare the widened shifted remainder with the divisor and restore.
    always_comb begin
        shifted = {rem_in, bit_in};
        dvs_ext = {1'b0, divisor};
        fits    = (shifted >= dvs_ext);
        rem_out = fits ? WIDTH'(shifted - dvs_ext) : shifted[WIDTH-1:0];
        quo_out = {quo_in[WIDTH-2:0], fits};
    end
endmodule

// File: rtl/div_datapath.sv
// Operand and result registers of the divider. The bit index picks the
// dividend bit fed to the step logic, so the dividend register itself is
// never shifted.
// Assumes: load and step are never high together (sequencer guarantees).
module div_datapath #(
    parameter  int WIDTH = 32,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [IDX_W-1:0] bit_idx,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder
);
    logic [WIDTH-1:0] dvd_q, dvs_q, rem_q, quo_q;
    logic [WIDTH-1:0] rem_nx, quo_nx;
    logic             sel_bit;

    // Bit index selects the dividend bit brought into this step.
    assign sel_bit = dvd_q[bit_idx];

    div_step #(.WIDTH(WIDTH)) u_step (
        .rem_in  (rem_q),
        .bit_in  (sel_bit),
        .divisor (dvs_q),
        .quo_in  (quo_q),
        .rem_out (rem_nx),
        .quo_out (quo_nx)
    );

    // Capture operands on load, advance the partial results on each step.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            dvd_q <= '0;
            dvs_q <= '0;
            rem_q <= '0;
            quo_q <= '0;
        end else if (load) begin
            dvd_q <= dividend;
            dvs_q <= divisor;
            rem_q <= '0;
            quo_q <= '0;
        end else if (step) begin
            rem_q <= rem_nx;
            quo_q <= quo_nx;
        end
    end

    assign quotient  = quo_q;
    assign remainder = rem_q;

    // R2: a load clears both result registers.
    a_r2_load_clears: assert property (@(posedge clk) disable iff (!rst_n)
        load |=> (quo_q == '0 && rem_q == '0));

    // R5: with a nonzero divisor the partial remainder stays below it.
    a_r5_rem_bound: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dvs_q != '0) |-> (rem_q < dvs_q));

    // R6: with a zero divisor every step yields a quotient bit of one.
    a_r6_zero_ones: assert property (@(posedge clk) disable iff (!rst_n)
        (step && dvs_q == '0) |=> quo_q[0]);

    // R7: with neither load nor step the results do not move.
    a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && !step) |=> ($stable(quo_q) && $stable(rem_q)));
endmodule

// File: rtl/restoring_divider.sv
// Top of the multi-cycle unsigned restoring divider: one quotient bit per
// clock, WIDTH compute cycles per division, done pulsed once at the end.
// Assumes: synchronous active-low reset; WIDTH >= 2.
module restoring_divider #(
    parameter  int WIDTH = 32,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [WIDTH-1:0] dividend,
    input  logic [WIDTH-1:0] divisor,
    output logic             done,
    output logic [WIDTH-1:0] quotient,
    output logic [WIDTH-1:0] remainder
);
    logic             load, step;
    logic [IDX_W-1:0] bit_idx;

    div_seq_ctrl #(.WIDTH(WIDTH)) u_ctrl (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (start),
        .load    (load),
        .step    (step),
        .done    (done),
        .bit_idx (bit_idx)
    );

    div_datapath #(.WIDTH(WIDTH)) u_dp (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .step      (step),
        .bit_idx   (bit_idx),
        .dividend  (dividend),
        .divisor   (divisor),
        .quotient  (quotient),
        .remainder (remainder)
    );

    // R3: a start during a run neither restarts nor disturbs the counter.
    a_r3_start_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (start && step && bit_idx != '0) |=> (step && bit_idx == $past(bit_idx) - 1'b1));
endmodule

// File: tb/tb_restoring_divider.sv
`timescale 1ns/1ps
module tb_restoring_divider;
    localparam int SW = 6;
    localparam int WW = 32;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #2.5 clk = ~clk;

    logic          s_start = 1'b0, w_start = 1'b0;
    logic [SW-1:0] s_a = '0, s_b = '0, s_q, s_r;
    logic [WW-1:0] w_a = '0, w_b = '0, w_q, w_r;
    logic          s_done, w_done;

    int n_chk  = 0;
    int n_fail = 0;

    restoring_divider #(.WIDTH(SW)) dut (
        .clk(clk), .rst_n(rst_n), .start(s_start), .dividend(s_a),
        .divisor(s_b), .done(s_done), .quotient(s_q), .remainder(s_r));

    restoring_divider #(.WIDTH(WW)) dut_wide (
        .clk(clk), .rst_n(rst_n), .start(w_start), .dividend(w_a),
        .divisor(w_b), .done(w_done), .quotient(w_q), .remainder(w_r));

    task automatic chk(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exv);
        end
    endtask

    // Narrow instance: one division, optional start poke mid-run (R3).
    task automatic run_small(input logic [SW-1:0] a, input logic [SW-1:0] b,
                             input bit poke);
        logic [SW-1:0] eq, er;
        int lat;
        eq  = (b == 0) ? {SW{1'b1}} : a / b;
        er  = (b == 0) ? a : a % b;
        lat = 0;
        @(negedge clk); s_a = a; s_b = b; s_start = 1'b1;
        @(negedge clk); s_start = 1'b0;
        chk(s_q == 0 && s_r == 0, "R2 cleared", {s_q, s_r}, 0);
        for (int k = 1; k <= SW + 4; k++) begin
            @(negedge clk);
            if (s_done) begin lat = k; break; end
            if (poke && k == 2) begin s_start = 1'b1; s_a = ~a; s_b = b ^ 1; end
            else if (k == 3) s_start = 1'b0;
        end
        s_start = 1'b0;
        chk(lat == SW, (b == 0) ? "R6 latency" : "R4 latency", lat, SW);
        chk(s_q == eq, (b == 0) ? "R6 quotient" : (poke ? "R3 quotient" : "R5 quotient"), s_q, eq);
        chk(s_r == er, (b == 0) ? "R6 remainder" : (poke ? "R3 remainder" : "R5 remainder"), s_r, er);
        @(negedge clk);
        chk(!s_done, "R4 single pulse", s_done, 0);
        chk(s_q == eq && s_r == er, "R7 hold", {s_q, s_r}, {eq, er});
    endtask

    // Wide instance: one division, always pokes start mid-run (R3).
    task automatic run_wide(input logic [WW-1:0] a, input logic [WW-1:0] b);
        logic [WW-1:0] eq, er;
        int lat;
        eq  = (b == 0) ? '1 : a / b;
        er  = (b == 0) ? a : a % b;
        lat = 0;
        @(negedge clk); w_a = a; w_b = b; w_start = 1'b1;
        @(negedge clk); w_start = 1'b0;
        for (int k = 1; k <= WW + 4; k++) begin
            @(negedge clk);
            if (w_done) begin lat = k; break; end
            if (k == 5) begin w_start = 1'b1; w_a = a ^ 32'h5A5A_0F0F; w_b = b + 1; end
            else if (k == 6) w_start = 1'b0;
        end
        w_start = 1'b0;
        chk(lat == WW, (b == 0) ? "R6 latency" : "R4 latency", lat, WW);
        chk(w_q == eq, (b == 0) ? "R6 quotient" : "R5 R3 quotient", w_q, eq);
        chk(w_r == er, (b == 0) ? "R6 remainder" : "R5 R3 remainder", w_r, er);
        // R7: operands wander with start low; results must not move.
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); w_a = ~w_a; w_b = w_b + 7;
            chk(!w_done && w_q == eq && w_r == er, "R7 idle hold",
                {w_q, w_r}, {eq, er});
        end
    endtask

    initial begin
        logic [31:0] x;
        repeat (3) @(negedge clk);
        // R1: outputs while reset is held.
        chk(!s_done && s_q == 0 && s_r == 0, "R1 narrow in reset", {s_q, s_r}, 0);
        chk(!w_done && w_q == 0 && w_r == 0, "R1 wide in reset", {w_q, w_r}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!s_done && s_q == 0 && s_r == 0, "R1 narrow after reset", {s_q, s_r}, 0);
        chk(!w_done && w_q == 0 && w_r == 0, "R1 wide after reset", {w_q, w_r}, 0);

        // Exhaustive narrow sweep (R4, R5, R6, R3 on odd dividends).
        for (int a = 0; a < (1 << SW); a++)
            for (int b = 0; b < (1 << SW); b++)
                run_small(SW'(a), SW'(b), a[0]);

        // Directed wide cases.
        run_wide(32'd45, 32'd3);
        run_wide(32'hDEAD_BEEF, 32'd0);
        run_wide(32'hFFFF_FFFF, 32'd1);
        run_wide(32'hFFFF_FFFF, 32'hFFFF_FFFF);
        run_wide(32'd7, 32'd10);
        run_wide(32'h8000_0000, 32'd3);
        run_wide(32'h8000_0000, 32'hFFFF_FFFF);
        run_wide(32'd0, 32'd0);
        // Generated wide cases (xorshift operands).
        x = 32'h1234_5678;
        for (int i = 0; i < 40; i++) begin
            logic [31:0] a, b;
            x ^= x << 13; x ^= x >> 17; x ^= x << 5; a = x;
            x ^= x << 13; x ^= x >> 17; x ^= x << 5;
            b = (i % 3 == 0) ? (x >> (i % 29)) : x;
            run_wide(a, b);
        end

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (120000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule